// File: doc/BRIEF.md
# Hardware/Software Shared Register Field

This block is one storage field inside a memory-mapped register. Both software and on-chip logic can write it. Software reaches it through an already-decoded write strobe, which carries write data and per-bit enables, and through a read strobe. Hardware reaches it through three controls: a load of a next-value input gated by a write enable, a set of all bits, and a clear of all bits.

The write semantics are fixed when the field is built. `WR_MODE` selects one of four: plain write, write-one-to-clear, write-one-to-set, or a self-clearing pulse. A gate input can veto software writes. Software updates and hardware updates that land in the same cycle are resolved by fixed precedence. The field drives its current value, a software-access strobe, a software-modify strobe, and AND, OR and XOR reductions of its value.

Each cycle the update arbiter picks one of three decisions:
- **SRC_HOLD**: no request, so the value is kept.
- **SRC_SW**: a software write, or the pending self-clear, is applied.
- **SRC_HW**: the winning hardware action is applied.

Transitions between these decisions depend only on the requests present in the current cycle:
- HOLD→SW when software alone requests.
- HOLD→HW when hardware alone requests.
- When both request, the winner is SW if `HW_PRIORITY`=0 and HW if `HW_PRIORITY`=1.
- Any decision returns to HOLD when no request is present.

In pulse mode a separate pending flag is raised by a software write that wins. In the next cycle that flag issues a zero write with software rank.

Top module: `shared_reg_field`

## Requirements
- R1: With `HAS_RESET`=1, asserting `rst_n` low forces the value to `RESET_VAL`.
- R2: A software write affects only the bits whose enable is 1. In plain mode (`WR_MODE`=0) those bits take the write data and the other bits keep their value.
- R3: Write-one-to-clear mode (`WR_MODE`=1) clears exactly the enabled bits written as 1. Write-one-to-set mode (`WR_MODE`=2) sets exactly those bits. All other bits are unchanged.
- R4: In pulse mode (`WR_MODE`=3) a software write is stored, and the field reads zero on the following cycle. Two exceptions apply: another software write in that cycle wins, and a hardware update with priority in that cycle wins.
- R5: When the gate input denies writes, a software write changes nothing and raises neither strobe. The gate denies writes when it is low with `GATE_LOW`=0, and when it is high with `GATE_LOW`=1.
- R6: Among hardware actions, set beats clear and clear beats load. Set drives all ones; clear drives all zeros.
- R7: Hardware loads `hw_next_i` only while the write enable is active. The enable is active high with `WE_LOW`=0 and active low with `WE_LOW`=1. With no request the value holds.
- R8: When software and hardware both update in one cycle, software wins if `HW_PRIORITY`=0 and hardware wins if `HW_PRIORITY`=1.
- R9: `sw_acc_o` is high, combinationally, in exactly those cycles that carry a read strobe or a write permitted by the gate.
- R10: `sw_mod_o` is high only in a cycle where a software write wins and its result differs from the current value.
- R11: `and_o`, `or_o` and `xor_o` are the AND, OR and XOR reductions of the current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_wr_i | input | 1 | Decoded software write strobe |
| sw_rd_i | input | 1 | Decoded software read strobe |
| sw_wdata_i | input | WIDTH | Software write data |
| sw_wbe_i | input | WIDTH | Per-bit write enables |
| sw_gate_i | input | 1 | Software write permission (polarity set by GATE_LOW) |
| hw_we_i | input | 1 | Hardware load enable (polarity set by WE_LOW) |
| hw_next_i | input | WIDTH | Hardware next value |
| hw_set_i | input | 1 | Hardware set of all bits |
| hw_clr_i | input | 1 | Hardware clear of all bits |
| value_o | output | WIDTH | Current field value |
| sw_acc_o | output | 1 | Software access strobe |
| sw_mod_o | output | 1 | Software modify strobe |
| and_o | output | 1 | AND reduction of the value |
| or_o | output | 1 | OR reduction of the value |
| xor_o | output | 1 | XOR reduction of the value |

## Verification
The assertions assume that the read and write strobes are single-cycle pulses from a decoder. They also assume that the gate and enable inputs are stable, known levels around each clock edge, and that no input is X once reset is released.

The bench respects these assumptions in three ways:
- It changes every input only on the falling edge.
- It returns all strobes to idle after each cycle.
- It drives the active-low instance through explicit inversions of the same logical stimulus, so both polarity settings see legal, settled levels.

// File: rtl/shared_field_pkg.sv
package shared_field_pkg;

    typedef enum logic [1:0] {
        WM_PLAIN = 2'd0,
        WM_CLR1  = 2'd1,
        WM_SET1  = 2'd2,
        WM_PULSE = 2'd3
    } wmode_e;

    typedef enum logic [1:0] {
        HW_IDLE = 2'd0,
        HW_SET  = 2'd1,
        HW_CLR  = 2'd2,
        HW_LOAD = 2'd3
    } hw_kind_e;

    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_SW   = 2'd1,
        SRC_HW   = 2'd2
    } upd_src_e;

endpackage

// File: rtl/swf_sw_path.sv
module swf_sw_path
    import shared_field_pkg::*;
#(
    parameter int     WIDTH    = 8,
    parameter wmode_e WR_MODE  = WM_PLAIN,
    parameter bit     GATE_LOW = 1'b0
) (
    input  logic [WIDTH-1:0] q_i,
    input  logic             sw_wr_i,
    input  logic             sw_rd_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [WIDTH-1:0] wbe_i,
    input  logic             gate_i,
    input  logic             pend_i,
    output logic             wr_ok_o,
    output logic             req_o,
    output logic [WIDTH-1:0] val_o,
    output logic             acc_o
);
    logic             allow;
    logic [WIDTH-1:0] hit;
    logic [WIDTH-1:0] written;

    assign allow   = GATE_LOW ? ~gate_i : gate_i;
    assign wr_ok_o = sw_wr_i & allow;
    assign hit     = wdata_i & wbe_i;
    assign acc_o   = sw_rd_i | wr_ok_o;

    always_comb begin
        unique case (WR_MODE)
            WM_CLR1:  written = q_i & ~hit;
            WM_SET1:  written = q_i | hit;
            default:  written = (q_i & ~wbe_i) | hit;
        endcase
    end

    always_comb begin
        if (wr_ok_o) begin
            req_o = 1'b1;
            val_o = written;
        end else if (pend_i) begin
            req_o = 1'b1;
            val_o = '0;
        end else begin
            req_o = 1'b0;
            val_o = q_i;
        end
    end
endmodule

// File: rtl/swf_hw_path.sv
module swf_hw_path
    import shared_field_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter bit WE_LOW = 1'b0
) (
    input  logic             hw_set_i,
    input  logic             hw_clr_i,
    input  logic             hw_we_i,
    input  logic [WIDTH-1:0] hw_next_i,
    output logic             req_o,
    output logic [WIDTH-1:0] val_o
);
    hw_kind_e kind;
    logic     load_en;

    assign load_en = WE_LOW ? ~hw_we_i : hw_we_i;

    always_comb begin
        if (hw_set_i)      kind = HW_SET;
        else if (hw_clr_i) kind = HW_CLR;
        else if (load_en)  kind = HW_LOAD;
        else               kind = HW_IDLE;
    end

    always_comb begin
        unique case (kind)
            HW_SET:  val_o = '1;
            HW_CLR:  val_o = '0;
            HW_LOAD: val_o = hw_next_i;
            default: val_o = '0;
        endcase
    end

    assign req_o = (kind != HW_IDLE);
endmodule

// File: rtl/swf_reduce.sv
module swf_reduce #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] val_i,
    output logic             and_o,
    output logic             or_o,
    output logic             xor_o
);
    assign and_o = &val_i;
    assign or_o  = |val_i;
    assign xor_o = ^val_i;
endmodule

// File: rtl/shared_reg_field.sv
module shared_reg_field
    import shared_field_pkg::*;
#(
    parameter int         WIDTH       = 8,
    parameter wmode_e     WR_MODE     = WM_PLAIN,
    parameter bit         GATE_LOW    = 1'b0,
    parameter bit         WE_LOW      = 1'b0,
    parameter bit         HW_PRIORITY = 1'b0,
    parameter bit         HAS_RESET   = 1'b1,
    parameter [WIDTH-1:0] RESET_VAL   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr_i,
    input  logic             sw_rd_i,
    input  logic [WIDTH-1:0] sw_wdata_i,
    input  logic [WIDTH-1:0] sw_wbe_i,
    input  logic             sw_gate_i,
    input  logic             hw_we_i,
    input  logic [WIDTH-1:0] hw_next_i,
    input  logic             hw_set_i,
    input  logic             hw_clr_i,
    output logic [WIDTH-1:0] value_o,
    output logic             sw_acc_o,
    output logic             sw_mod_o,
    output logic             and_o,
    output logic             or_o,
    output logic             xor_o
);
    localparam bit SW_FIRST   = (HW_PRIORITY == 1'b0);
    localparam bit PULSE_MODE = (WR_MODE == WM_PULSE);

    logic [WIDTH-1:0] q, q_nxt, sw_val, hw_val;
    logic             sw_req, sw_wr_ok, hw_req, pend;
    upd_src_e         src;

    swf_sw_path #(.WIDTH(WIDTH), .WR_MODE(WR_MODE), .GATE_LOW(GATE_LOW)) u_sw (
        .q_i(q), .sw_wr_i(sw_wr_i), .sw_rd_i(sw_rd_i), .wdata_i(sw_wdata_i),
        .wbe_i(sw_wbe_i), .gate_i(sw_gate_i), .pend_i(pend),
        .wr_ok_o(sw_wr_ok), .req_o(sw_req), .val_o(sw_val), .acc_o(sw_acc_o)
    );

    swf_hw_path #(.WIDTH(WIDTH), .WE_LOW(WE_LOW)) u_hw (
        .hw_set_i(hw_set_i), .hw_clr_i(hw_clr_i), .hw_we_i(hw_we_i),
        .hw_next_i(hw_next_i), .req_o(hw_req), .val_o(hw_val)
    );

    swf_reduce #(.WIDTH(WIDTH)) u_red (
        .val_i(q), .and_o(and_o), .or_o(or_o), .xor_o(xor_o)
    );

    // update decision: HOLD, SW or HW
    always_comb begin
        if (sw_req && hw_req) src = SW_FIRST ? SRC_SW : SRC_HW;
        else if (sw_req)      src = SRC_SW;
        else if (hw_req)      src = SRC_HW;
        else                  src = SRC_HOLD;
    end

    always_comb begin
        unique case (src)
            SRC_SW:  q_nxt = sw_val;
            SRC_HW:  q_nxt = hw_val;
            default: q_nxt = q;
        endcase
    end

    generate
        if (HAS_RESET) begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= RESET_VAL;
                else        q <= q_nxt;
            end
        end else begin : g_norst
            always_ff @(posedge clk) begin
                q <= q_nxt;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= PULSE_MODE && (src == SRC_SW) && sw_wr_ok;
    end

    assign value_o  = q;
    assign sw_mod_o = (src == SRC_SW) && sw_wr_ok && (sw_val != q);

    // ---------------- assertions ----------------
    logic wr_allowed;
    assign wr_allowed = GATE_LOW ? ~sw_gate_i : sw_gate_i;

    p_denied_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_i && !wr_allowed && !sw_rd_i) |-> (!sw_acc_o && !sw_mod_o));

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set_i && !(sw_req && SW_FIRST)) |=> (&value_o));

    p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_req && !hw_req) |=> $stable(value_o));

    p_mod_has_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_mod_o |-> sw_acc_o);

    p_mod_changes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_mod_o |=> (value_o != $past(value_o)));

    p_and_implies_or_r11: assert property (@(posedge clk) disable iff (!rst_n)
        and_o |-> (or_o && (value_o != '0)));

    generate
        if (PULSE_MODE) begin : g_pulse_chk
            p_pulse_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
                ((src == SRC_SW) && sw_wr_ok) ##1 (!sw_wr_ok && !hw_req)
                |=> (value_o == '0));
        end
    endgenerate
endmodule

// File: tb/shared_reg_field_bench.sv
module shared_reg_field_bench;
    import shared_field_pkg::*;

    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_wr = 0, sw_rd = 0, gate = 1, hw_we = 0, hw_set = 0, hw_clr = 0;
    logic [W-1:0] wdata = '0, wbe = '0, hw_next = '0;
    logic gate_n, we_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign gate_n = ~gate;
    assign we_n   = ~hw_we;

    logic [W-1:0] v_p, v_c, v_s, v_u;
    logic acc_p, mod_p, and_p, or_p, xor_p;
    logic acc_c, mod_c, and_c, or_c, xor_c;
    logic acc_s, mod_s, and_s, or_s, xor_s;
    logic acc_u, mod_u, and_u, or_u, xor_u;
    logic c_acc_p, c_mod_p, c_mod_s, c_acc_u, c_mod_u;

    shared_reg_field #(.WIDTH(W), .WR_MODE(WM_PLAIN), .RESET_VAL(8'h5A)) u_shared_reg_field (
        .clk(clk), .rst_n(rst_n), .sw_wr_i(sw_wr), .sw_rd_i(sw_rd), .sw_wdata_i(wdata),
        .sw_wbe_i(wbe), .sw_gate_i(gate), .hw_we_i(hw_we), .hw_next_i(hw_next),
        .hw_set_i(hw_set), .hw_clr_i(hw_clr), .value_o(v_p), .sw_acc_o(acc_p),
        .sw_mod_o(mod_p), .and_o(and_p), .or_o(or_p), .xor_o(xor_p));

    shared_reg_field #(.WIDTH(W), .WR_MODE(WM_CLR1), .RESET_VAL(8'h5A)) u_shared_reg_field_w1c (
        .clk(clk), .rst_n(rst_n), .sw_wr_i(sw_wr), .sw_rd_i(sw_rd), .sw_wdata_i(wdata),
        .sw_wbe_i(wbe), .sw_gate_i(gate), .hw_we_i(hw_we), .hw_next_i(hw_next),
        .hw_set_i(hw_set), .hw_clr_i(hw_clr), .value_o(v_c), .sw_acc_o(acc_c),
        .sw_mod_o(mod_c), .and_o(and_c), .or_o(or_c), .xor_o(xor_c));

    shared_reg_field #(.WIDTH(W), .WR_MODE(WM_SET1), .RESET_VAL(8'h5A)) u_shared_reg_field_w1s (
        .clk(clk), .rst_n(rst_n), .sw_wr_i(sw_wr), .sw_rd_i(sw_rd), .sw_wdata_i(wdata),
        .sw_wbe_i(wbe), .sw_gate_i(gate), .hw_we_i(hw_we), .hw_next_i(hw_next),
        .hw_set_i(hw_set), .hw_clr_i(hw_clr), .value_o(v_s), .sw_acc_o(acc_s),
        .sw_mod_o(mod_s), .and_o(and_s), .or_o(or_s), .xor_o(xor_s));

    shared_reg_field #(.WIDTH(W), .WR_MODE(WM_PULSE), .GATE_LOW(1'b1), .WE_LOW(1'b1),
                       .HW_PRIORITY(1'b1), .RESET_VAL(8'h5A)) u_shared_reg_field_pls (
        .clk(clk), .rst_n(rst_n), .sw_wr_i(sw_wr), .sw_rd_i(sw_rd), .sw_wdata_i(wdata),
        .sw_wbe_i(wbe), .sw_gate_i(gate_n), .hw_we_i(we_n), .hw_next_i(hw_next),
        .hw_set_i(hw_set), .hw_clr_i(hw_clr), .value_o(v_u), .sw_acc_o(acc_u),
        .sw_mod_o(mod_u), .and_o(and_u), .or_o(or_u), .xor_o(xor_u));

    task automatic chk(input string req, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // inputs are set right after a falling edge; strobes captured before the
    // rising edge, registered values visible at the next falling edge
    task automatic step();
        #2;
        c_acc_p = acc_p; c_mod_p = mod_p; c_mod_s = mod_s;
        c_acc_u = acc_u; c_mod_u = mod_u;
        @(negedge clk);
        sw_wr = 0; sw_rd = 0; wdata = '0; wbe = '0; gate = 1;
        hw_we = 0; hw_set = 0; hw_clr = 0; hw_next = '0;
    endtask

    task automatic swwrite(input logic [W-1:0] d, input logic [W-1:0] be);
        sw_wr = 1; wdata = d; wbe = be;
    endtask

    task automatic t_reset();
        chk("R1", "plain reset", v_p, 8'h5A);
        chk("R1", "pulse reset", v_u, 8'h5A);
        chk("R11", "and at 5A", {7'd0, and_p}, 8'd0);
        chk("R11", "or at 5A", {7'd0, or_p}, 8'd1);
        chk("R11", "xor at 5A", {7'd0, xor_p}, 8'd0);
    endtask

    task automatic t_masked_write();
        swwrite(8'hC3, 8'h0F); step();
        chk("R2", "plain masked", v_p, 8'h53);
        chk("R3", "w1c masked", v_c, 8'h58);
        chk("R3", "w1s masked", v_s, 8'h5B);
        chk("R4", "pulse stored", v_u, 8'h53);
        chk("R9", "acc on write", {7'd0, c_acc_p}, 8'd1);
        chk("R10", "mod on change", {7'd0, c_mod_p}, 8'd1);
        step();
        chk("R4", "pulse self-clear", v_u, 8'h00);
        chk("R2", "plain holds", v_p, 8'h53);
    endtask

    task automatic t_gate_denied();
        swwrite(8'hFF, 8'hFF); gate = 0; step();
        chk("R5", "plain unchanged", v_p, 8'h53);
        chk("R5", "w1c unchanged", v_c, 8'h58);
        chk("R5", "w1s unchanged", v_s, 8'h5B);
        chk("R5", "pulse unchanged", v_u, 8'h00);
        chk("R5", "no acc", {7'd0, c_acc_p}, 8'd0);
        chk("R5", "no mod", {7'd0, c_mod_p}, 8'd0);
        chk("R5", "no acc low-pol", {7'd0, c_acc_u}, 8'd0);
    endtask

    task automatic t_read();
        sw_rd = 1; step();
        chk("R9", "acc on read", {7'd0, c_acc_p}, 8'd1);
        chk("R10", "no mod on read", {7'd0, c_mod_p}, 8'd0);
        chk("R9", "read keeps value", v_p, 8'h53);
    endtask

    task automatic t_same_value();
        swwrite(8'h53, 8'hFF); step();
        chk("R9", "acc same-value write", {7'd0, c_acc_p}, 8'd1);
        chk("R10", "no mod same value", {7'd0, c_mod_p}, 8'd0);
        chk("R10", "no mod w1s no change", {7'd0, c_mod_s}, 8'd0);
        chk("R3", "w1c full", v_c, 8'h08);
        step();
    endtask

    task automatic t_hw_order();
        hw_set = 1; hw_clr = 1; step();
        chk("R6", "set over clr", v_p, 8'hFF);
        chk("R6", "set over clr pulse", v_u, 8'hFF);
        hw_clr = 1; hw_we = 1; hw_next = 8'h3C; step();
        chk("R6", "clr over load", v_p, 8'h00);
        hw_we = 1; hw_next = 8'h3C; step();
        chk("R7", "load", v_p, 8'h3C);
        chk("R7", "load low-pol", v_u, 8'h3C);
        hw_next = 8'h99; step();
        chk("R7", "no load without we", v_p, 8'h3C);
        chk("R7", "no load low-pol", v_u, 8'h3C);
    endtask

    task automatic t_precedence();
        swwrite(8'hF0, 8'hFF); hw_we = 1; hw_next = 8'h0F; step();
        chk("R8", "sw wins plain", v_p, 8'hF0);
        chk("R8", "sw wins w1c", v_c, 8'h0C);
        chk("R8", "sw wins w1s", v_s, 8'hFC);
        chk("R8", "hw wins pulse", v_u, 8'h0F);
        chk("R10", "mod when sw wins", {7'd0, c_mod_p}, 8'd1);
        chk("R10", "no mod when sw loses", {7'd0, c_mod_u}, 8'd0);
        chk("R9", "acc when sw loses", {7'd0, c_acc_u}, 8'd1);
        step();
        chk("R4", "no self-clear after loss", v_u, 8'h0F);
        swwrite(8'h00, 8'hFF); hw_set = 1; step();
        chk("R8", "sw beats set plain", v_p, 8'h00);
        chk("R8", "sw beats set w1c", v_c, 8'h0C);
        chk("R8", "set beats sw pulse", v_u, 8'hFF);
    endtask

    task automatic t_reduce();
        hw_set = 1; step();
        chk("R11", "and all ones", {7'd0, and_p}, 8'd1);
        chk("R11", "xor all ones", {7'd0, xor_p}, 8'd0);
        hw_we = 1; hw_next = 8'h01; step();
        chk("R11", "and 01", {7'd0, and_p}, 8'd0);
        chk("R11", "or 01", {7'd0, or_p}, 8'd1);
        chk("R11", "xor 01", {7'd0, xor_p}, 8'd1);
        hw_clr = 1; step();
        chk("R11", "or zero", {7'd0, or_p}, 8'd0);
        chk("R11", "xor zero", {7'd0, xor_p}, 8'd0);
    endtask

    task automatic t_pulse_corners();
        swwrite(8'hA5, 8'hFF); step();
        chk("R4", "pulse A5", v_u, 8'hA5);
        swwrite(8'h0F, 8'hFF); step();
        chk("R4", "new write beats self-clear", v_u, 8'h0F);
        step();
        chk("R4", "clear after second write", v_u, 8'h00);
        swwrite(8'h77, 8'hFF); step();
        hw_we = 1; hw_next = 8'h11; step();
        chk("R4", "hw beats self-clear", v_u, 8'h11);
        step();
        chk("R4", "self-clear dropped", v_u, 8'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masked_write();
        t_gate_denied();
        t_read();
        t_same_value();
        t_hw_order();
        t_precedence();
        t_reduce();
        t_pulse_corners();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule